// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one low-level operation at a time against a single NAND flash chip: block erase, page program, page read, or an in-chip copy-back that patches part of a page before writing it to a new row. A controller hands it an opcode, a row address (block and page), a column offset, a destination row for copy-back and a byte count. The sequencer then walks the chip through the command, address, data-in, busy-wait, data-out and status phases that the opcode needs, one bus event per clock, and ends with a single-cycle done pulse that carries a pass/fail flag.

The flash side is a simplified byte bus with four strobes: command latch, address latch, data write and data read. Address bytes always go out least significant byte first, with the two column bytes ahead of the three row bytes. Busy time comes from a down-counter loaded with a per-operation cycle count. With `USE_RB` set, the counter value is only a minimum, and the wait also holds until the chip's ready/busy line reads high. A page carries 2112 bytes, made up of four 512-byte sectors and 16 spare bytes per sector. The byte count port is sized to hold that value.

Top module: `nand_op_sequencer`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` is 0 and no bus strobe is active.
- R2: A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the next cycle until the done pulse, and `cmd_valid` has no effect during that time. `cmd_ready` is high again in the cycle after done.
- R3: Opcode 0 (erase) produces this bus sequence: command 0x60, then the three row bytes, then command 0xD0, then the erase wait, then command 0x70, then one status read.
- R4: Opcode 1 (program) produces this bus sequence: command 0x80, then two column bytes and three row bytes, then `cmd_len` data writes taken from `wr_data` (`wr_take` high on each write), then command 0x10, then the program wait, then the status command and read.
- R5: Opcode 2 (read) produces this bus sequence: command 0x00, then five address bytes, then command 0x30, then the read wait, then `cmd_len` data reads, then the status command and read. Each data read is presented on `rd_data` with `rd_valid` high in the same cycle.
- R6: Opcode 3 (copy-back) produces this bus sequence: command 0x00, then the column and source row, then command 0x35, then the read wait, then command 0x85, then the column and `cmd_dst` row, then `cmd_len` patch writes, then command 0x10, then the program wait, then the status command and read.
- R7: In timer mode, the first bus event after a confirm command (0xD0, 0x10, 0x30, 0x35) comes exactly T+2 cycles later. T is `T_ERASE`, `T_PROG` or `T_READ` for an erase, program or read wait respectively. No strobe is active during a wait. With `USE_RB` set, the wait also holds until `fb_rb` is high.
- R8: `done` is high for one cycle, in the cycle directly after the status read strobe. `done_fail` equals bit 0 of the status byte that was read.
- R9: With `cmd_len` = 0, the data phase of program, read and copy-back is skipped entirely.
- R10: At most one of `fb_cle`, `fb_ale`, `fb_we`, `fb_re` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle; the command is taken this cycle |
| cmd_op | input | 2 | 0 erase, 1 program, 2 read, 3 copy-back |
| cmd_row | input | 24 | Row address (block and page) |
| cmd_col | input | 16 | Column offset for the data phase |
| cmd_dst | input | 24 | Destination row for copy-back |
| cmd_len | input | 12 | Number of data bytes to move |
| wr_data | input | 8 | Byte to write in the data-in phase |
| wr_take | output | 1 | `wr_data` is consumed this cycle |
| rd_data | output | 8 | Byte read from the chip |
| rd_valid | output | 1 | `rd_data` holds a page byte this cycle |
| fb_cle | output | 1 | Command byte on `fb_dout` |
| fb_ale | output | 1 | Address byte on `fb_dout` |
| fb_we | output | 1 | Data byte on `fb_dout` |
| fb_re | output | 1 | Read strobe; chip drives `fb_din` |
| fb_dout | output | 8 | Byte from the sequencer to the chip |
| fb_din | input | 8 | Byte from the chip to the sequencer |
| fb_rb | input | 1 | Chip ready (1) / busy (0) |
| done | output | 1 | One-cycle completion pulse |
| done_fail | output | 1 | Status check failed; valid while `done` is high |

## Verification
The hardest case to reach is a copy-back. It has two separate busy waits and two address phases, and it can also have a zero-length patch or a failing status byte. The stimulus mixes directed copy-back runs, with lengths of zero and non-zero and with both pass and fail status, into a seeded random series of opcodes, addresses and lengths. A behavioural chip stub answers status and data reads. Holding `cmd_valid` high with a different opcode right after acceptance checks the hold-off: the whole recorded bus trace must match only the first command.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_PROG  = 2'd1,
        OP_READ  = 2'd2,
        OP_COPY  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD_A,
        ST_ADDR_A,
        ST_CMD_B,
        ST_WAIT_A,
        ST_CMD_C,
        ST_ADDR_B,
        ST_DIN,
        ST_CMD_D,
        ST_WAIT_B,
        ST_DOUT,
        ST_STAT_CMD,
        ST_STAT_RD,
        ST_DONE
    } step_e;

    localparam logic [7:0] CB_READ_SETUP  = 8'h00;
    localparam logic [7:0] CB_READ_GO     = 8'h30;
    localparam logic [7:0] CB_COPY_LOAD   = 8'h35;
    localparam logic [7:0] CB_PROG_SETUP  = 8'h80;
    localparam logic [7:0] CB_COPY_PROG   = 8'h85;
    localparam logic [7:0] CB_PROG_GO     = 8'h10;
    localparam logic [7:0] CB_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CB_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CB_STATUS      = 8'h70;

endpackage

// File: rtl/nand_seq_timer.sv
module nand_seq_timer #(
    parameter int CNT_W  = 8,
    parameter int USE_RB = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    input  logic             rb,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.cnt = load;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - CNT_W'(1);
        end
        expired = !start && (t_q.cnt == '0) && (rb || (USE_RB == 0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    // R7: a non-zero wait cannot end in the cycle right after it is armed
    p_no_early_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && load != '0) |=> !expired);

endmodule

// File: rtl/nand_seq_index.sv
module nand_seq_index #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] idx
);

    typedef struct packed {
        logic [W-1:0] idx;
    } idx_s;

    idx_s i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (clr) begin
            i_d.idx = '0;
        end else if (inc) begin
            i_d.idx = i_q.idx + W'(1);
        end
        idx = i_q.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    // R4: each phase restarts its byte index at zero
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (idx == '0));

endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
    import nand_seq_pkg::*;
#(
    parameter int ROW_BYTES    = 3,
    parameter int COL_BYTES    = 2,
    parameter int SECTORS      = 4,
    parameter int SECTOR_BYTES = 512,
    parameter int SPARE_BYTES  = 16,
    parameter int T_ERASE      = 200,
    parameter int T_PROG       = 60,
    parameter int T_READ       = 12,
    parameter int USE_RB       = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [1:0]               cmd_op,
    input  logic [8*ROW_BYTES-1:0]   cmd_row,
    input  logic [8*COL_BYTES-1:0]   cmd_col,
    input  logic [8*ROW_BYTES-1:0]   cmd_dst,
    input  logic [$clog2(SECTORS*(SECTOR_BYTES+SPARE_BYTES)+1)-1:0] cmd_len,
    input  logic [7:0]               wr_data,
    output logic                     wr_take,
    output logic [7:0]               rd_data,
    output logic                     rd_valid,
    output logic                     fb_cle,
    output logic                     fb_ale,
    output logic                     fb_we,
    output logic                     fb_re,
    output logic [7:0]               fb_dout,
    input  logic [7:0]               fb_din,
    input  logic                     fb_rb,
    output logic                     done,
    output logic                     done_fail
);

    localparam int ROW_W      = 8 * ROW_BYTES;
    localparam int COL_W      = 8 * COL_BYTES;
    localparam int ADDR_BYTES = ROW_BYTES + COL_BYTES;
    localparam int PAGE_BYTES = SECTORS * (SECTOR_BYTES + SPARE_BYTES);
    localparam int LEN_W      = $clog2(PAGE_BYTES + 1);
    localparam int T_MAX_A    = (T_ERASE > T_PROG) ? T_ERASE : T_PROG;
    localparam int T_MAX      = (T_MAX_A > T_READ) ? T_MAX_A : T_READ;
    localparam int TMR_W      = $clog2(T_MAX + 1);

    typedef struct packed {
        step_e            step;
        op_e              op;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] dst;
        logic [LEN_W-1:0] len;
        logic             fail;
    } seq_s;

    seq_s s_d, s_q;

    logic                     idx_clr, idx_inc;
    logic [LEN_W-1:0]         idx;
    logic                     tmr_start, tmr_expired;
    logic [TMR_W-1:0]         tmr_load;
    logic [8*ADDR_BYTES-1:0]  avec;
    logic [LEN_W-1:0]         abase, apos;
    logic [7:0]               abyte;
    logic                     a_last, d_last;

    nand_seq_index #(.W(LEN_W)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idx_clr),
        .inc   (idx_inc),
        .idx   (idx)
    );

    nand_seq_timer #(.CNT_W(TMR_W), .USE_RB(USE_RB)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .load    (tmr_load),
        .rb      (fb_rb),
        .expired (tmr_expired)
    );

    // address byte selection: column bytes first, then row, low byte first
    always_comb begin
        avec   = (s_q.step == ST_ADDR_B) ? {s_q.dst, s_q.col} : {s_q.row, s_q.col};
        abase  = (s_q.op == OP_ERASE) ? LEN_W'(COL_BYTES) : '0;
        apos   = idx + abase;
        abyte  = 8'(avec >> {apos, 3'b000});
        a_last = (apos == LEN_W'(ADDR_BYTES - 1));
        d_last = (idx == s_q.len - LEN_W'(1));
    end

    always_comb begin
        s_d       = s_q;
        cmd_ready = 1'b0;
        idx_clr   = 1'b0;
        idx_inc   = 1'b0;
        tmr_start = 1'b0;
        tmr_load  = '0;
        fb_cle    = 1'b0;
        fb_ale    = 1'b0;
        fb_we     = 1'b0;
        fb_re     = 1'b0;
        fb_dout   = '0;
        wr_take   = 1'b0;
        rd_valid  = 1'b0;
        rd_data   = fb_din;

        unique case (s_q.step)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    s_d.op   = op_e'(cmd_op);
                    s_d.row  = cmd_row;
                    s_d.col  = cmd_col;
                    s_d.dst  = cmd_dst;
                    s_d.len  = cmd_len;
                    s_d.fail = 1'b0;
                    s_d.step = ST_CMD_A;
                    idx_clr  = 1'b1;
                end
            end
            ST_CMD_A: begin
                fb_cle = 1'b1;
                unique case (s_q.op)
                    OP_ERASE: fb_dout = CB_ERASE_SETUP;
                    OP_PROG:  fb_dout = CB_PROG_SETUP;
                    default:  fb_dout = CB_READ_SETUP;
                endcase
                idx_clr  = 1'b1;
                s_d.step = ST_ADDR_A;
            end
            ST_ADDR_A: begin
                fb_ale  = 1'b1;
                fb_dout = abyte;
                if (a_last) begin
                    idx_clr = 1'b1;
                    if (s_q.op == OP_PROG && s_q.len != '0) begin
                        s_d.step = ST_DIN;
                    end else begin
                        s_d.step = ST_CMD_B;
                    end
                end else begin
                    idx_inc = 1'b1;
                end
            end
            ST_DIN: begin
                fb_we   = 1'b1;
                fb_dout = wr_data;
                wr_take = 1'b1;
                if (d_last) begin
                    idx_clr  = 1'b1;
                    s_d.step = (s_q.op == OP_PROG) ? ST_CMD_B : ST_CMD_D;
                end else begin
                    idx_inc = 1'b1;
                end
            end
            ST_CMD_B: begin
                fb_cle    = 1'b1;
                tmr_start = 1'b1;
                unique case (s_q.op)
                    OP_ERASE: begin
                        fb_dout  = CB_ERASE_GO;
                        tmr_load = TMR_W'(T_ERASE);
                    end
                    OP_PROG: begin
                        fb_dout  = CB_PROG_GO;
                        tmr_load = TMR_W'(T_PROG);
                    end
                    OP_READ: begin
                        fb_dout  = CB_READ_GO;
                        tmr_load = TMR_W'(T_READ);
                    end
                    default: begin
                        fb_dout  = CB_COPY_LOAD;
                        tmr_load = TMR_W'(T_READ);
                    end
                endcase
                s_d.step = ST_WAIT_A;
            end
            ST_WAIT_A: begin
                if (tmr_expired) begin
                    idx_clr = 1'b1;
                    unique case (s_q.op)
                        OP_READ: s_d.step = (s_q.len != '0) ? ST_DOUT : ST_STAT_CMD;
                        OP_COPY: s_d.step = ST_CMD_C;
                        default: s_d.step = ST_STAT_CMD;
                    endcase
                end
            end
            ST_CMD_C: begin
                fb_cle   = 1'b1;
                fb_dout  = CB_COPY_PROG;
                idx_clr  = 1'b1;
                s_d.step = ST_ADDR_B;
            end
            ST_ADDR_B: begin
                fb_ale  = 1'b1;
                fb_dout = abyte;
                if (a_last) begin
                    idx_clr  = 1'b1;
                    s_d.step = (s_q.len != '0) ? ST_DIN : ST_CMD_D;
                end else begin
                    idx_inc = 1'b1;
                end
            end
            ST_CMD_D: begin
                fb_cle    = 1'b1;
                fb_dout   = CB_PROG_GO;
                tmr_start = 1'b1;
                tmr_load  = TMR_W'(T_PROG);
                s_d.step  = ST_WAIT_B;
            end
            ST_WAIT_B: begin
                if (tmr_expired) begin
                    s_d.step = ST_STAT_CMD;
                end
            end
            ST_DOUT: begin
                fb_re    = 1'b1;
                rd_valid = 1'b1;
                if (d_last) begin
                    idx_clr  = 1'b1;
                    s_d.step = ST_STAT_CMD;
                end else begin
                    idx_inc = 1'b1;
                end
            end
            ST_STAT_CMD: begin
                fb_cle   = 1'b1;
                fb_dout  = CB_STATUS;
                s_d.step = ST_STAT_RD;
            end
            ST_STAT_RD: begin
                fb_re    = 1'b1;
                s_d.fail = fb_din[0];
                s_d.step = ST_DONE;
            end
            ST_DONE: begin
                s_d.step = ST_IDLE;
            end
            default: begin
                s_d.step = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{step: ST_IDLE, op: OP_ERASE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done      = (s_q.step == ST_DONE);
    assign done_fail = s_q.fail;

    // R10: never more than one strobe per cycle
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fb_cle, fb_ale, fb_we, fb_re}));

    // R7: the bus stays quiet while the chip is busy
    p_quiet_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == ST_WAIT_A || s_q.step == ST_WAIT_B) |->
            !(fb_cle || fb_ale || fb_we || fb_re));

    // R8: done directly follows the status read strobe
    p_done_after_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fb_re));

    // R2: an accepted command holds off further commands
    p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R2: ready returns right after done
    p_ready_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cmd_ready && !done));

endmodule

// File: tb/tb_nand_op_sequencer.sv
`timescale 1ns/1ps
module tb_nand_op_sequencer;

    localparam int T_ERASE = 200;
    localparam int T_PROG  = 60;
    localparam int T_READ  = 12;
    localparam int LOGN    = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [23:0] cmd_row = '0;
    logic [15:0] cmd_col = '0;
    logic [23:0] cmd_dst = '0;
    logic [11:0] cmd_len = '0;
    logic [7:0]  wr_data;
    logic        wr_take;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        fb_cle, fb_ale, fb_we, fb_re;
    logic [7:0]  fb_dout, fb_din;
    logic        fb_rb = 1'b1;
    logic        done, done_fail;

    always #4 clk = ~clk;

    nand_op_sequencer #(
        .T_ERASE(T_ERASE), .T_PROG(T_PROG), .T_READ(T_READ), .USE_RB(0)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_dst(cmd_dst),
        .cmd_len(cmd_len), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .fb_cle(fb_cle), .fb_ale(fb_ale),
        .fb_we(fb_we), .fb_re(fb_re), .fb_dout(fb_dout), .fb_din(fb_din),
        .fb_rb(fb_rb), .done(done), .done_fail(done_fail)
    );

    // behavioural chip stub
    logic stub_stat = 1'b0;
    logic stub_fail = 1'b0;
    int   stub_rcnt = 0;
    always @(posedge clk) begin
        if (fb_cle) begin
            stub_stat <= (fb_dout == 8'h70);
            stub_rcnt <= 0;
        end else if (fb_re && !stub_stat) begin
            stub_rcnt <= stub_rcnt + 1;
        end
    end
    assign fb_din = stub_stat ? (8'hC0 | {7'd0, stub_fail}) : (8'(stub_rcnt) ^ 8'hA5);

    // write data source
    logic [7:0] wr_base = 8'h00;
    int         wr_cnt = 0;
    always @(posedge clk) begin
        if (cmd_valid && cmd_ready) wr_cnt <= 0;
        else if (wr_take)           wr_cnt <= wr_cnt + 1;
    end
    assign wr_data = wr_base + 8'(wr_cnt);

    // bus monitor
    int   cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;
    int   log_kind [LOGN];
    int   log_byte [LOGN];
    int   log_cyc  [LOGN];
    int   log_n = 0;
    bit   log_en = 1'b0;
    bit   done_seen = 1'b0;
    bit   done_fail_seen = 1'b0;
    int   done_cyc = 0;
    int   multi_strobe = 0;

    task automatic push_log(input int k, input int b);
        if (log_n < LOGN) begin
            log_kind[log_n] = k;
            log_byte[log_n] = b;
            log_cyc[log_n]  = cyc;
        end
        log_n++;
    endtask

    always @(negedge clk) begin
        if (rst_n && (int'(fb_cle) + int'(fb_ale) + int'(fb_we) + int'(fb_re)) > 1)
            multi_strobe++;
        if (log_en) begin
            if (fb_cle) push_log(0, int'(fb_dout));
            if (fb_ale) push_log(1, int'(fb_dout));
            if (fb_we)  push_log(2, int'(fb_dout));
            if (fb_re && rd_valid)  push_log(3, int'(rd_data));
            if (fb_re && !rd_valid) push_log(4, int'(fb_din));
            if (done) begin
                done_seen      = 1'b1;
                done_fail_seen = done_fail;
                done_cyc       = cyc;
            end
        end
    end

    // checking
    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    int exp_kind [LOGN];
    int exp_byte [LOGN];
    int exp_n = 0;

    task automatic ex(input int k, input int b);
        if (exp_n < LOGN) begin
            exp_kind[exp_n] = k;
            exp_byte[exp_n] = b;
        end
        exp_n++;
    endtask

    task automatic build(input int op, input logic [23:0] row, input logic [15:0] col,
                         input logic [23:0] dst, input int len, input bit fail);
        exp_n = 0;
        case (op)
            0: begin
                ex(0, 8'h60);
                for (int b = 0; b < 3; b++) ex(1, int'(8'(row >> (8*b))));
                ex(0, 8'hD0);
            end
            1: begin
                ex(0, 8'h80);
                for (int b = 0; b < 2; b++) ex(1, int'(8'(col >> (8*b))));
                for (int b = 0; b < 3; b++) ex(1, int'(8'(row >> (8*b))));
                for (int k = 0; k < len; k++) ex(2, int'(wr_base + 8'(k)));
                ex(0, 8'h10);
            end
            2: begin
                ex(0, 8'h00);
                for (int b = 0; b < 2; b++) ex(1, int'(8'(col >> (8*b))));
                for (int b = 0; b < 3; b++) ex(1, int'(8'(row >> (8*b))));
                ex(0, 8'h30);
                for (int k = 0; k < len; k++) ex(3, int'(8'(k) ^ 8'hA5));
            end
            default: begin
                ex(0, 8'h00);
                for (int b = 0; b < 2; b++) ex(1, int'(8'(col >> (8*b))));
                for (int b = 0; b < 3; b++) ex(1, int'(8'(row >> (8*b))));
                ex(0, 8'h35);
                ex(0, 8'h85);
                for (int b = 0; b < 2; b++) ex(1, int'(8'(col >> (8*b))));
                for (int b = 0; b < 3; b++) ex(1, int'(8'(dst >> (8*b))));
                for (int k = 0; k < len; k++) ex(2, int'(wr_base + 8'(k)));
                ex(0, 8'h10);
            end
        endcase
        ex(0, 8'h70);
        ex(4, int'(8'hC0 | {7'd0, fail}));
    endtask

    task automatic run_op(input int op, input logic [23:0] row, input logic [15:0] col,
                          input logic [23:0] dst, input int len, input bit fail,
                          input bit hold);
        string tag;
        int    mism;
        tag = (op == 0) ? "R3" : (op == 1) ? "R4" : (op == 2) ? "R5" : "R6";
        if (len == 0 && op != 0) tag = {tag, "/R9"};
        stub_fail = fail;
        wr_base   = 8'($urandom);
        log_n     = 0;
        done_seen = 1'b0;
        log_en    = 1'b1;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_row   = row;
        cmd_col   = col;
        cmd_dst   = dst;
        cmd_len   = 12'(len);
        @(negedge clk);
        if (hold) begin
            cmd_op  = 2'(op + 1);
            cmd_row = ~row;
            for (int h = 0; h < 3; h++) begin
                chk(cmd_ready == 1'b0, "R2 hold-off ready", int'(cmd_ready), 0);
                @(negedge clk);
            end
        end
        cmd_valid = 1'b0;
        while (!done_seen) @(negedge clk);
        log_en = 1'b0;
        build(op, row, col, dst, len, fail);
        chk(log_n == exp_n, {tag, " event count"}, log_n, exp_n);
        mism = -1;
        for (int i = 0; i < exp_n && i < log_n && i < LOGN; i++) begin
            if (mism < 0 && (log_kind[i] != exp_kind[i] || log_byte[i] != exp_byte[i]))
                mism = i;
        end
        if (mism >= 0)
            chk(1'b0, {tag, " sequence"}, log_kind[mism] * 256 + log_byte[mism],
                exp_kind[mism] * 256 + exp_byte[mism]);
        else
            chk(1'b1, {tag, " sequence"}, 0, 0);
        for (int i = 0; i + 1 < log_n && i + 1 < LOGN; i++) begin
            if (log_kind[i] == 0 && (log_byte[i] == 8'hD0 || log_byte[i] == 8'h10 ||
                                     log_byte[i] == 8'h30 || log_byte[i] == 8'h35)) begin
                int t;
                t = (log_byte[i] == 8'hD0) ? T_ERASE :
                    (log_byte[i] == 8'h10) ? T_PROG : T_READ;
                chk(log_cyc[i+1] - log_cyc[i] == t + 2, "R7 busy gap",
                    log_cyc[i+1] - log_cyc[i], t + 2);
            end
        end
        chk(done_fail_seen == fail, "R8 done_fail", int'(done_fail_seen), int'(fail));
        if (log_n > 0 && log_n <= LOGN)
            chk(log_kind[log_n-1] == 4 && done_cyc == log_cyc[log_n-1] + 1,
                "R8 done timing", done_cyc - log_cyc[log_n-1], 1);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R2 ready after done", int'(cmd_ready), 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk({fb_cle, fb_ale, fb_we, fb_re} == 4'b0, "R1 strobes",
            int'({fb_cle, fb_ale, fb_we, fb_re}), 0);

        // directed cases
        run_op(0, 24'h123456, 16'h0000, 24'h0, 0, 1'b0, 1'b1);  // R3 erase + R2 hold-off
        run_op(0, 24'h00ABCD, 16'h0000, 24'h0, 0, 1'b1, 1'b0);  // R3 erase failing
        run_op(1, 24'h010203, 16'h0840, 24'h0, 5, 1'b0, 1'b0);  // R4
        run_op(1, 24'h0A0B0C, 16'h0004, 24'h0, 0, 1'b1, 1'b0);  // R9 program
        run_op(2, 24'h332211, 16'h0100, 24'h0, 7, 1'b0, 1'b1);  // R5 + R2
        run_op(2, 24'h000001, 16'h0000, 24'h0, 0, 1'b0, 1'b0);  // R9 read
        run_op(3, 24'h004000, 16'h0200, 24'h004040, 4, 1'b0, 1'b0); // R6
        run_op(3, 24'h004001, 16'h0000, 24'h004041, 0, 1'b1, 1'b0); // R6/R9 fail
        run_op(3, 24'h0F0F0F, 16'h083F, 24'h00F0F0, 1, 1'b1, 1'b1); // R6 + R2

        // seeded random mix
        for (int n = 0; n < 24; n++) begin
            run_op(int'($urandom % 4), 24'($urandom), 16'($urandom % 2112),
                   24'($urandom), int'($urandom % 25), 1'($urandom), 1'($urandom % 2));
        end

        chk(multi_strobe == 0, "R10 single strobe", multi_strobe, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule